// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block is the first-level control decoder of a small single-cycle processor. It looks only at the six-bit major opcode of the current instruction. From it the block drives the datapath steering lines: destination-register select, second-operand select, write-back source, register write enable, memory read and write strobes, branch and jump flags, and a two-bit operation class.

The operation class does not name a final ALU function. It tells a separate second-level decoder whether to force an add, force a subtract, or decode the function field. The block also resolves the next program counter. It takes the branch target when a branch meets a zero ALU result, and it takes the pseudo-direct jump target on a jump. In all other cases it passes PC+4.

Everything is combinational. Outputs that have no meaning for a given instruction are driven to 0. An opcode that the block does not recognise leaves every write enable and every control-flow flag low.

Top module: `ctl_main_decoder`

## Requirements
- R1: Opcode 000000 (register-register) gives dst_rd=1, src_imm=0, wb_mem=0, reg_we=1, mem_re=0, mem_we=0, branch=0, jump=0, alu_class=10.
- R2: Opcode 100011 (load word) gives dst_rd=0, src_imm=1, wb_mem=1, reg_we=1, mem_re=1, mem_we=0, branch=0, jump=0, alu_class=00.
- R3: Opcode 101011 (store word) gives src_imm=1, mem_we=1, and every other line 0, with alu_class=00.
- R4: Opcode 000100 (branch if equal) gives branch=1, alu_class=01, and every other line 0.
- R5: Opcode 000010 (jump) gives jump=1, alu_class=00, and every other line 0.
- R6: Any other opcode drives every control line to 0 and alu_class to 00. next_pc is then PC+4 whatever zero_i is.
- R7: pc_src is 1 exactly when branch is 1 and zero_i is 1. In that case next_pc equals branch_target_i.
- R8: Without a taken branch and without a jump, next_pc equals pc_plus4_i. This includes a branch-if-equal with zero_i=0.
- R9: On a jump, next_pc is pc_plus4_i[31:28] concatenated with jump_index_i and two zero bits.
- R10: At most one of reg_we, mem_we, branch and jump is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Major opcode, instruction bits 31:26 |
| zero_i | input | 1 | ALU result-is-zero flag |
| pc_plus4_i | input | 32 | Sequential next address |
| branch_target_i | input | 32 | Precomputed branch destination |
| jump_index_i | input | 26 | Instruction index field of a jump |
| dst_rd_o | output | 1 | 1: write rd field, 0: write rt field |
| src_imm_o | output | 1 | 1: second ALU operand is the extended immediate |
| wb_mem_o | output | 1 | 1: write back memory data, 0: ALU result |
| reg_we_o | output | 1 | Register file write enable |
| mem_re_o | output | 1 | Data memory read strobe |
| mem_we_o | output | 1 | Data memory write strobe |
| branch_o | output | 1 | Conditional branch instruction |
| jump_o | output | 1 | Unconditional jump instruction |
| alu_class_o | output | 2 | 00 add, 01 subtract, 10 decode function field |
| pc_src_o | output | 1 | Branch taken |
| next_pc_o | output | 32 | Resolved next program counter |

## Verification
Immediate assertions run every time the decoder's or the PC resolver's inputs change. They check the exclusivity of write enables and control-flow flags, that an unknown opcode leaves the machine untouched, and that a taken branch and a jump each route the proper address. The exact line values for each instruction class can only be shown by the bench's scenarios, which compare against a table built from the requirements. So can the jump address assembly across random indices and upper PC bits, and the not-taken branch falling through to PC+4.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int unsigned OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_RR   = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STOR = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ  = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JMP  = 6'b000010;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_SUB  = 2'b01,
    ALU_FUNC = 2'b10
  } alu_class_e;

  typedef struct packed {
    logic       dst_rd;
    logic       src_imm;
    logic       wb_mem;
    logic       reg_we;
    logic       mem_re;
    logic       mem_we;
    logic       branch;
    logic       jump;
    alu_class_e alu_class;
  } ctrl_t;
endpackage

// File: rtl/ctl_opcode_decode.sv
module ctl_opcode_decode
  import ctl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output ctrl_t            ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    ctrl_o.alu_class = ALU_ADD;
    unique case (opcode_i)
      OPC_RR: begin
        ctrl_o.dst_rd    = 1'b1;
        ctrl_o.reg_we    = 1'b1;
        ctrl_o.alu_class = ALU_FUNC;
      end
      OPC_LOAD: begin
        ctrl_o.src_imm = 1'b1;
        ctrl_o.wb_mem  = 1'b1;
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.mem_re  = 1'b1;
      end
      OPC_STOR: begin
        ctrl_o.src_imm = 1'b1;
        ctrl_o.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl_o.branch    = 1'b1;
        ctrl_o.alu_class = ALU_SUB;
      end
      OPC_JMP: ctrl_o.jump = 1'b1;
      default: ;
    endcase

    // a_r10_one_effect
    a_r10_one_effect: assert ($onehot0({ctrl_o.reg_we, ctrl_o.mem_we, ctrl_o.branch, ctrl_o.jump}))
      else $error("R10 more than one effect asserted");
    // a_r2_read_needs_wb: a memory read must feed a register write
    a_r2_read_needs_wb: assert (!ctrl_o.mem_re || (ctrl_o.wb_mem && ctrl_o.reg_we))
      else $error("R2 read without write-back");
    // a_r6_unknown_quiet
    if (!(opcode_i inside {OPC_RR, OPC_LOAD, OPC_STOR, OPC_BEQ, OPC_JMP}))
      a_r6_unknown_quiet: assert (ctrl_o == '0)
        else $error("R6 unknown opcode has effect");
  end
endmodule

// File: rtl/ctl_next_pc.sv
module ctl_next_pc #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 26
) (
  input  logic              branch_i,
  input  logic              jump_i,
  input  logic              zero_i,
  input  logic [ADDR_W-1:0] pc_plus4_i,
  input  logic [ADDR_W-1:0] branch_target_i,
  input  logic [IDX_W-1:0]  jump_index_i,
  output logic              pc_src_o,
  output logic [ADDR_W-1:0] next_pc_o
);
  localparam int unsigned HI_W = ADDR_W - IDX_W - 2;

  logic [ADDR_W-1:0] jump_target;

  always_comb begin
    jump_target = {pc_plus4_i[ADDR_W-1 -: HI_W], jump_index_i, 2'b00};
    pc_src_o    = branch_i & zero_i;
    if (jump_i)        next_pc_o = jump_target;
    else if (pc_src_o) next_pc_o = branch_target_i;
    else               next_pc_o = pc_plus4_i;

    a_r7_taken_target: assert (!(branch_i && zero_i) || next_pc_o == branch_target_i)
      else $error("R7 taken branch misrouted");
    a_r8_fallthrough: assert (jump_i || (branch_i && zero_i) || next_pc_o == pc_plus4_i)
      else $error("R8 sequential path misrouted");
    a_r9_jump_low_bits: assert (!jump_i || next_pc_o[1:0] == 2'b00)
      else $error("R9 jump target misaligned");
  end
endmodule

// File: rtl/ctl_main_decoder.sv
module ctl_main_decoder
  import ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 26
) (
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic              zero_i,
  input  logic [ADDR_W-1:0] pc_plus4_i,
  input  logic [ADDR_W-1:0] branch_target_i,
  input  logic [IDX_W-1:0]  jump_index_i,
  output logic              dst_rd_o,
  output logic              src_imm_o,
  output logic              wb_mem_o,
  output logic              reg_we_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic              branch_o,
  output logic              jump_o,
  output logic [1:0]        alu_class_o,
  output logic              pc_src_o,
  output logic [ADDR_W-1:0] next_pc_o
);
  ctrl_t ctrl;

  ctl_opcode_decode u_dec (
    .opcode_i (opcode_i),
    .ctrl_o   (ctrl)
  );

  ctl_next_pc #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_npc (
    .branch_i        (ctrl.branch),
    .jump_i          (ctrl.jump),
    .zero_i          (zero_i),
    .pc_plus4_i      (pc_plus4_i),
    .branch_target_i (branch_target_i),
    .jump_index_i    (jump_index_i),
    .pc_src_o        (pc_src_o),
    .next_pc_o       (next_pc_o)
  );

  assign dst_rd_o    = ctrl.dst_rd;
  assign src_imm_o   = ctrl.src_imm;
  assign wb_mem_o    = ctrl.wb_mem;
  assign reg_we_o    = ctrl.reg_we;
  assign mem_re_o    = ctrl.mem_re;
  assign mem_we_o    = ctrl.mem_we;
  assign branch_o    = ctrl.branch;
  assign jump_o      = ctrl.jump;
  assign alu_class_o = ctrl.alu_class;
endmodule

// File: tb/tb_ctl_main_decoder.sv
module tb_ctl_main_decoder;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [5:0]  opcode;
  logic        zero;
  logic [31:0] pc4, btgt;
  logic [25:0] jidx;
  logic dst_rd, src_imm, wb_mem, reg_we, mem_re, mem_we, branch, jump, pc_src;
  logic [1:0]  alu_class;
  logic [31:0] next_pc;

  int checks = 0;
  int errors = 0;

  ctl_main_decoder dut (
    .opcode_i(opcode), .zero_i(zero), .pc_plus4_i(pc4),
    .branch_target_i(btgt), .jump_index_i(jidx),
    .dst_rd_o(dst_rd), .src_imm_o(src_imm), .wb_mem_o(wb_mem),
    .reg_we_o(reg_we), .mem_re_o(mem_re), .mem_we_o(mem_we),
    .branch_o(branch), .jump_o(jump), .alu_class_o(alu_class),
    .pc_src_o(pc_src), .next_pc_o(next_pc)
  );

  // {dst_rd,src_imm,wb_mem,reg_we,mem_re,mem_we,branch,jump,alu_class}
  function automatic logic [9:0] exp_ctrl(input logic [5:0] op);
    case (op)
      6'b000000: return 10'b1001000010; // R1
      6'b100011: return 10'b0111100000; // R2
      6'b101011: return 10'b0100010000; // R3
      6'b000100: return 10'b0000001001; // R4
      6'b000010: return 10'b0000000100; // R5
      default:   return 10'b0000000000; // R6
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] op);
    case (op)
      6'b000000: return "R1";
      6'b100011: return "R2";
      6'b101011: return "R3";
      6'b000100: return "R4";
      6'b000010: return "R5";
      default:   return "R6";
    endcase
  endfunction

  task automatic apply_and_check(input logic [5:0] op, input logic z);
    logic [9:0]  act, exp;
    logic [31:0] exp_pc;
    logic        exp_src;
    opcode = op; zero = z;
    @(negedge clk);
    exp = exp_ctrl(op);
    act = {dst_rd, src_imm, wb_mem, reg_we, mem_re, mem_we, branch, jump, alu_class};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%b ctrl act=%b exp=%b", tag_of(op), op, act, exp);
    end
    exp_src = (op == 6'b000100) && z;
    if (op == 6'b000010) exp_pc = {pc4[31:28], jidx, 2'b00};
    else if (exp_src)    exp_pc = btgt;
    else                 exp_pc = pc4;
    checks++;
    if (pc_src !== exp_src || next_pc !== exp_pc) begin
      errors++;
      $display("FAIL %s op=%b z=%b pc_src/next_pc act=%b/%h exp=%b/%h",
               (op == 6'b000010) ? "R9" : exp_src ? "R7" : "R8",
               op, z, pc_src, next_pc, exp_src, exp_pc);
    end
    checks++;
    if (!$onehot0({reg_we, mem_we, branch, jump})) begin
      errors++;
      $display("FAIL R10 op=%b effects act=%b exp=onehot0", op, {reg_we, mem_we, branch, jump});
    end
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] legal [5];
    legal[0] = 6'b000000; legal[1] = 6'b100011; legal[2] = 6'b101011;
    legal[3] = 6'b000100; legal[4] = 6'b000010;
    void'($urandom(32'd1234));
    opcode = '0; zero = 1'b0; pc4 = 32'h0040_0004; btgt = 32'h0040_0100; jidx = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    // directed corners
    apply_and_check(6'b000000, 1'b1);      // R1 initial opcode
    apply_and_check(6'b100011, 1'b1);      // R2
    apply_and_check(6'b101011, 1'b1);      // R3
    apply_and_check(6'b000100, 1'b1);      // R4 R7 taken
    apply_and_check(6'b000100, 1'b0);      // R8 not taken
    pc4 = 32'hF000_0000; jidx = 26'h3FF_FFFF;
    apply_and_check(6'b000010, 1'b0);      // R5 R9
    apply_and_check(6'b111111, 1'b1);      // R6
    apply_and_check(6'b000101, 1'b1);      // R6 near branch opcode
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [5:0] op;
      pc4  = $urandom;
      btgt = $urandom;
      jidx = 26'($urandom);
      op = ($urandom % 3 == 0) ? 6'($urandom) : legal[$urandom % 5];
      apply_and_check(op, 1'($urandom));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule